// File: doc/BRIEF.md
# Periodic Serial ADC Capture Controller

This block is the master side of a link to a serial ADC. It divides the system clock into a serial clock and counts a sample interval in whole serial-clock periods. When the interval expires, it opens one active-low chip-select frame. During the frame it shifts in the converter's word, most significant bit first, and captures each bit on a falling serial-clock edge. At the end of a full word it presents the low bits right-justified, together with a one-cycle valid strobe.

Every frame start is locked to the serial clock. After an expiry, the sequencer waits for the clock to be high, then low, then high again before it pulls chip-select low. Consecutive frames are therefore separated by an exact whole number of serial-clock periods. Holding the power-down request when a frame opens replaces the full word with a short burst, which places the converter in its low-power state. An expiry that arrives while a frame is still being prepared or run is reported as an overrun and is dropped, not queued.

Top module: `adc_frame_ctrl`

## Requirements
- R1: The serial clock output has a period of 2*(clk_div+1) system clocks while a frame runs, and is held high whenever cs_n_o is high.
- R2: With run_en high and no overrun, consecutive cs_n_o falling edges are exactly sample_ivl serial-clock periods apart. Each period is 2*(clk_div+1) system clocks.
- R3: cs_n_o falls only while sclk_o is high, and the first falling sclk_o edge of a frame follows clk_div+1 system clocks later.
- R4: A full frame keeps cs_n_o low for exactly 16 serial-clock periods and contains exactly 16 falling sclk_o edges.
- R5: Bits are sampled from sdata_i at the falling sclk_o edges, first bit as most significant. data_o carries the last DATA_W bits received, with the final bit at bit 0.
- R6: data_valid_o is high for exactly one system clock per full frame, in the cycle in which the 16th falling sclk_o edge appears, and while cs_n_o is still low.
- R7: If pd_req is high when a frame opens, that frame keeps cs_n_o low for exactly 8 serial-clock periods with 8 falling edges, raises no data_valid_o, and leaves data_o unchanged.
- R8: Between frames, cs_n_o stays high for at least one full serial-clock period.
- R9: An interval expiry that occurs from one expiry's acceptance until the resulting frame's cs_n_o rising edge gives a one-clock overrun_o pulse and starts no frame. With n bits in the previous frame, the next frame therefore opens after ceil((n+2)/sample_ivl)*sample_ivl periods.
- R10: After reset, cs_n_o=1, sclk_o=1, data_valid_o=0, overrun_o=0 and data_o=0. While run_en is low, no new frame opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Enables the interval timer |
| clk_div | input | DIV_W | Serial clock divider value |
| sample_ivl | input | IVL_W | Sample interval in serial-clock periods |
| pd_req | input | 1 | Power-down burst request, sampled when a frame opens |
| sdata_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| cs_n_o | output | 1 | Active-low frame select |
| data_o | output | DATA_W | Right-justified received word |
| data_valid_o | output | 1 | One-cycle strobe for a new word |
| overrun_o | output | 1 | One-cycle pulse for a dropped interval expiry |

## Verification
A miscounted bit counter is visible at the very next cs_n_o rising edge: the low time or the falling-edge count differs from 16 or 8 periods. A wrong sync state or a wrong timer count shows at the next frame start, as a frame spacing that is not the predicted multiple of the interval, or as an overrun count that does not fit. A shifter fault appears on the first data_valid_o as a data mismatch. A mode latch fault appears as a missing or extra strobe in the frame where the mode is latched.

// File: rtl/adcf_pkg.sv
package adcf_pkg;
   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_WAIT_LO,
      SQ_WAIT_HI,
      SQ_SHIFT,
      SQ_TAIL
   } seq_state_t;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/adcf_sclk_gen.sv
module adcf_sclk_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_i,
   output logic             sclk_q,
   output logic             rise_tick,
   output logic             fall_tick
);
   logic [DIV_W-1:0] half_cnt;
   logic             wrap;

   assign wrap      = (half_cnt >= div_i);
   assign rise_tick = wrap & ~sclk_q;
   assign fall_tick = wrap & sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_cnt <= '0;
         sclk_q   <= 1'b1;
      end else if (wrap) begin
         half_cnt <= '0;
         sclk_q   <= ~sclk_q;
      end else begin
         half_cnt <= half_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/adcf_ivl_timer.sv
module adcf_ivl_timer #(
   parameter int IVL_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [IVL_W-1:0] ivl_i,
   input  logic             tick_i,
   output logic             expire_o
);
   logic [IVL_W-1:0] period_cnt;
   logic [IVL_W-1:0] last_val;

   assign last_val = (ivl_i == '0) ? '0 : ivl_i - 1'b1;
   assign expire_o = en_i & tick_i & (period_cnt >= last_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_cnt <= '0;
      end else if (!en_i) begin
         period_cnt <= '0;
      end else if (tick_i) begin
         period_cnt <= expire_o ? '0 : period_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/adcf_frame_seq.sv
module adcf_frame_seq
   import adcf_pkg::*;
#(
   parameter int FULL_BITS = 16,
   parameter int PD_BITS   = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rise_tick,
   input  logic fall_tick,
   input  logic start_i,
   input  logic pd_i,
   output logic cs_n_o,
   output logic shift_en_o,
   output logic word_done_o,
   output logic overrun_o
);
   localparam int BCW = cnt_width(FULL_BITS);
   localparam logic [BCW-1:0] FULL_LAST = BCW'(FULL_BITS - 1);
   localparam logic [BCW-1:0] PD_LAST   = BCW'(PD_BITS - 1);

   seq_state_t     state;
   logic [BCW-1:0] bit_cnt;
   logic           pd_lat;
   logic           last_bit;

   assign shift_en_o  = (state == SQ_SHIFT) & fall_tick;
   assign last_bit    = (bit_cnt == (pd_lat ? PD_LAST : FULL_LAST));
   assign word_done_o = shift_en_o & ~pd_lat & last_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SQ_IDLE;
         cs_n_o    <= 1'b1;
         bit_cnt   <= '0;
         pd_lat    <= 1'b0;
         overrun_o <= 1'b0;
      end else begin
         overrun_o <= start_i & (state != SQ_IDLE);
         unique case (state)
            SQ_IDLE:    if (start_i) state <= SQ_WAIT_LO;
            SQ_WAIT_LO: if (fall_tick) state <= SQ_WAIT_HI;
            SQ_WAIT_HI: if (rise_tick) begin
               state   <= SQ_SHIFT;
               cs_n_o  <= 1'b0;
               pd_lat  <= pd_i;
               bit_cnt <= '0;
            end
            SQ_SHIFT:   if (fall_tick) begin
               bit_cnt <= bit_cnt + 1'b1;
               if (last_bit) state <= SQ_TAIL;
            end
            SQ_TAIL:    if (rise_tick) begin
               state  <= SQ_IDLE;
               cs_n_o <= 1'b1;
            end
            default:    state <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/adcf_shift_rx.sv
module adcf_shift_rx #(
   parameter int WORD_BITS = 16,
   parameter int DATA_W    = 12,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_i,
   input  logic              done_i,
   input  logic              sdata_i,
   output logic [DATA_W-1:0] data_o,
   output logic              valid_o
);
   logic [WORD_BITS-1:0] shreg;
   logic [WORD_BITS-1:0] shreg_nxt;

   generate
      if (MSB_FIRST) begin : g_msb
         assign shreg_nxt = {shreg[WORD_BITS-2:0], sdata_i};
      end else begin : g_lsb
         assign shreg_nxt = {sdata_i, shreg[WORD_BITS-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg   <= '0;
         data_o  <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= done_i;
         if (shift_i) shreg <= shreg_nxt;
         if (done_i) data_o <= shreg_nxt[DATA_W-1:0];
      end
   end
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl #(
   parameter int DIV_W     = 8,
   parameter int IVL_W     = 12,
   parameter int WORD_BITS = 16,
   parameter int PD_BITS   = 8,
   parameter int DATA_W    = 12,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic [DIV_W-1:0]  clk_div,
   input  logic [IVL_W-1:0]  sample_ivl,
   input  logic              pd_req,
   input  logic              sdata_i,
   output logic              sclk_o,
   output logic              cs_n_o,
   output logic [DATA_W-1:0] data_o,
   output logic              data_valid_o,
   output logic              overrun_o
);
   generate
      if (WORD_BITS < 2) begin : g_bad_word
         $error("WORD_BITS must be at least 2");
      end
      if (PD_BITS < 1 || PD_BITS >= WORD_BITS) begin : g_bad_pd
         $error("PD_BITS must lie in 1..WORD_BITS-1");
      end
      if (DATA_W < 1 || DATA_W > WORD_BITS) begin : g_bad_data
         $error("DATA_W must lie in 1..WORD_BITS");
      end
      if (DIV_W < 1 || IVL_W < 1) begin : g_bad_cnt
         $error("counter widths must be positive");
      end
   endgenerate

   logic sclk_int, rise_tick, fall_tick, expire, shift_en, word_done;

   adcf_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
      .clk      (clk),
      .rst_n    (rst_n),
      .div_i    (clk_div),
      .sclk_q   (sclk_int),
      .rise_tick(rise_tick),
      .fall_tick(fall_tick)
   );

   adcf_ivl_timer #(.IVL_W(IVL_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (run_en),
      .ivl_i   (sample_ivl),
      .tick_i  (rise_tick),
      .expire_o(expire)
   );

   adcf_frame_seq #(.FULL_BITS(WORD_BITS), .PD_BITS(PD_BITS)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .rise_tick  (rise_tick),
      .fall_tick  (fall_tick),
      .start_i    (expire),
      .pd_i       (pd_req),
      .cs_n_o     (cs_n_o),
      .shift_en_o (shift_en),
      .word_done_o(word_done),
      .overrun_o  (overrun_o)
   );

   adcf_shift_rx #(.WORD_BITS(WORD_BITS), .DATA_W(DATA_W), .MSB_FIRST(MSB_FIRST)) u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .shift_i(shift_en),
      .done_i (word_done),
      .sdata_i(sdata_i),
      .data_o (data_o),
      .valid_o(data_valid_o)
   );

   assign sclk_o = cs_n_o | sclk_int;
endmodule

// File: rtl/adc_frame_ctrl_chk.sv
module adc_frame_ctrl_chk #(
   parameter int DIV_W     = 8,
   parameter int WORD_BITS = 16,
   parameter int PD_BITS   = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [DIV_W-1:0] clk_div,
   input logic             sclk_o,
   input logic             cs_n_o,
   input logic             data_valid_o,
   input logic             overrun_o
);
   int per;
   int hi_cnt;
   int lo_cnt;

   assign per = 2 * (int'(clk_div) + 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt <= 32'h3fff_ffff;
         lo_cnt <= 0;
      end else begin
         hi_cnt <= cs_n_o ? ((hi_cnt < 32'h3fff_ffff) ? hi_cnt + 1 : hi_cnt) : 0;
         lo_cnt <= cs_n_o ? 0 : lo_cnt + 1;
      end
   end

   AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_o |-> sclk_o); // R1
   AST_CS_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n_o) |-> sclk_o); // R3
   AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n_o) |-> (lo_cnt == WORD_BITS * per || lo_cnt == PD_BITS * per)); // R4
   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid_o |=> !data_valid_o); // R6
   AST_VALID_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid_o |-> !cs_n_o); // R6
   AST_GUARD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n_o) |-> (hi_cnt >= per)); // R8
   AST_OVR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      overrun_o |=> !overrun_o); // R9
endmodule

bind adc_frame_ctrl adc_frame_ctrl_chk #(
   .DIV_W(DIV_W), .WORD_BITS(WORD_BITS), .PD_BITS(PD_BITS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .sclk_o(sclk_o),
   .cs_n_o(cs_n_o), .data_valid_o(data_valid_o), .overrun_o(overrun_o)
);

// File: tb/sim_adc_frame_ctrl.sv
module sim_adc_frame_ctrl;
   localparam int DIV_W  = 8;
   localparam int IVL_W  = 12;
   localparam int DATA_W = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              run_en = 1'b0;
   logic [DIV_W-1:0]  clk_div = '0;
   logic [IVL_W-1:0]  sample_ivl = 12'd18;
   logic              pd_req = 1'b0;
   logic              sdata_i = 1'b0;
   logic              sclk_o, cs_n_o, data_valid_o, overrun_o;
   logic [DATA_W-1:0] data_o;

   adc_frame_ctrl #(.DIV_W(DIV_W), .IVL_W(IVL_W), .DATA_W(DATA_W)) u0 (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .clk_div(clk_div),
      .sample_ivl(sample_ivl), .pd_req(pd_req), .sdata_i(sdata_i),
      .sclk_o(sclk_o), .cs_n_o(cs_n_o), .data_o(data_o),
      .data_valid_o(data_valid_o), .overrun_o(overrun_o)
   );

   always #4 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // converter model: MSB first, next bit after each falling sclk edge
   logic [15:0] adc_word = '0;
   int          bit_idx = 0;
   always @(negedge cs_n_o) begin
      adc_word = 16'($urandom);
      bit_idx  = 15;
      sdata_i  = adc_word[15];
   end
   always @(negedge sclk_o) begin
      if (!cs_n_o && bit_idx > 0) begin
         bit_idx = bit_idx - 1;
         sdata_i = adc_word[bit_idx];
      end
   end

   function automatic int exp_spacing(input int prev_n, input int ivl);
      int k;
      k = (prev_n + 2 + ivl - 1) / ivl;
      return k * ivl;
   endfunction

   // monitor state
   int cur_div = 0;
   int cur_ivl = 18;
   int run_id = 0;
   int seen_run = 0;
   longint cyc = 0;
   longint t_fall = 0, t_rise = 0, t_sfall = 0;
   bit have_prev = 1'b0;
   int prev_n = 16, cur_n = 16;
   int sfalls = 0, vcnt = 0, ocnt = 0;
   int total_falls = 0, total_valid = 0, total_ovr = 0;
   bit prev_cs = 1'b1, prev_sclk = 1'b1;
   logic [DATA_W-1:0] last_data = '0;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         int per;
         cyc++;
         per = 2 * (cur_div + 1);
         if (seen_run != run_id) begin
            seen_run  = run_id;
            have_prev = 1'b0;
         end
         if (cs_n_o && !sclk_o) check(1'b0, "R1 sclk not high while idle", sclk_o, 1);
         if (overrun_o) begin
            ocnt++;
            total_ovr++;
         end
         if (prev_cs && !cs_n_o) begin
            total_falls++;
            check(sclk_o == 1'b1, "R3 cs fall with sclk high", sclk_o, 1);
            if (have_prev) begin
               check(cyc - t_rise >= per, "R8 high gap", cyc - t_rise, per);
               check(cyc - t_fall == longint'(exp_spacing(prev_n, cur_ivl) * per),
                     "R2/R9 frame spacing", cyc - t_fall, exp_spacing(prev_n, cur_ivl) * per);
               check(ocnt == exp_spacing(prev_n, cur_ivl) / cur_ivl - 1,
                     "R9 overrun count", ocnt, exp_spacing(prev_n, cur_ivl) / cur_ivl - 1);
            end
            t_fall = cyc;
            cur_n  = pd_req ? 8 : 16;
            sfalls = 0;
            vcnt   = 0;
            ocnt   = 0;
         end
         if (prev_sclk && !sclk_o && !cs_n_o) begin
            if (sfalls == 0)
               check(cyc - t_fall == per / 2, "R3 first sclk fall", cyc - t_fall, per / 2);
            else
               check(cyc - t_sfall == per, "R1 sclk period", cyc - t_sfall, per);
            sfalls++;
            t_sfall = cyc;
         end
         if (data_valid_o) begin
            vcnt++;
            total_valid++;
            check(data_o == adc_word[DATA_W-1:0], "R5 data word", data_o, adc_word[DATA_W-1:0]);
            check(!cs_n_o && sfalls == 16 && t_sfall == cyc, "R6 strobe timing", sfalls, 16);
            last_data = data_o;
         end
         if (!prev_cs && cs_n_o) begin
            check(cyc - t_fall == longint'(cur_n * per), "R4/R7 frame length",
                  cyc - t_fall, cur_n * per);
            check(sfalls == cur_n, "R4/R7 edge count", sfalls, cur_n);
            check(vcnt == ((cur_n == 16) ? 1 : 0), "R6/R7 strobe count", vcnt, (cur_n == 16) ? 1 : 0);
            if (cur_n == 8) check(data_o == last_data, "R7 data held", data_o, last_data);
            t_rise    = cyc;
            prev_n    = cur_n;
            have_prev = 1'b1;
         end
         prev_cs   = cs_n_o;
         prev_sclk = sclk_o;
      end
   end

   // pd_mode: 0 never, 1 always, 2 random
   task automatic run_case(input int div, input int ivl, input int pd_mode, input int frames);
      int falls_before;
      @(negedge clk);
      clk_div    = DIV_W'(div);
      sample_ivl = IVL_W'(ivl);
      cur_div    = div;
      cur_ivl    = ivl;
      pd_req     = (pd_mode == 1) || (pd_mode == 2 && ($urandom % 3 == 0));
      run_id++;
      run_en = 1'b1;
      for (int f = 0; f < frames; f++) begin
         @(posedge cs_n_o);
         #1;
         pd_req = (pd_mode == 1) || (pd_mode == 2 && ($urandom % 3 == 0));
      end
      run_en = 1'b0;
      pd_req = 1'b0;
      falls_before = total_falls;
      repeat (40 * 2 * (div + 1)) @(negedge clk);
      check(total_falls == falls_before, "R10 no frame while disabled", total_falls, falls_before);
   endtask

   initial begin
      int v0, ov0;
      void'($urandom(32'h1d5e_ed01));
      repeat (3) @(negedge clk);
      check(cs_n_o == 1'b1, "R10 reset cs_n", cs_n_o, 1);
      check(sclk_o == 1'b1, "R10 reset sclk", sclk_o, 1);
      check(data_valid_o == 1'b0, "R10 reset valid", data_valid_o, 0);
      check(overrun_o == 1'b0, "R10 reset overrun", overrun_o, 0);
      check(data_o == '0, "R10 reset data", data_o, 0);
      rst_n = 1'b1;
      repeat (50) @(negedge clk);
      check(total_falls == 0, "R10 idle without run_en", total_falls, 0);

      run_case(3, 18, 0, 5);          // 8 system clocks per serial clock, tight interval
      run_case(0, 18, 0, 5);          // fastest serial clock
      ov0 = total_ovr;
      run_case(1, 12, 0, 5);          // overrun every other expiry
      check(total_ovr > ov0, "R9 overrun seen", total_ovr - ov0, 1);
      v0 = total_valid;
      run_case(0, 10, 1, 4);          // power-down bursts only
      check(total_valid == v0, "R7 no strobe for bursts", total_valid - v0, 0);
      run_case(2, 7, 2, 6);           // mixed modes with overruns
      for (int r = 0; r < 6; r++)
         run_case(int'($urandom % 4), 5 + int'($urandom % 30), 2, 3 + int'($urandom % 4));
      finish_up();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual %0d expected %0d", 150000, 0);
      finish_up();
   end
endmodule